// File: doc/BRIEF.md
# Stepper Driver Sleep and Fault Supervisor

This block is the control and status supervisor of a micro-stepping motor driver. It collects raw fault flags from the power stage:

- thermal warning and thermal shutdown
- one overcurrent flag per X-bridge switch and per Y-bridge switch
- one open-coil flag per coil
- a charge-pump-low indication

It resynchronises these flags and merges them into a registered, active-low error line. It also publishes a charge-pump failure status bit for the status register.

The block sequences the driver through reset, sleep and wake. The sleep request from the control register puts the drivers into high impedance and blocks the step and direction inputs. Register contents outside the block are left alone during sleep. On every wake, and after every reset or hard clear, step commands stay blocked for a settle window of `CP_SETTLE_CYCLES` cycles. After the window they remain blocked for as long as the charge pump reports low. A step pulse that arrives while commands are blocked is discarded and is never replayed later.

The hard-clear input is active high and acts only after it has been held for `TCLR_CYCLES` consecutive clocks. Once it acts, it puts all digital state of the block back to its reset values. The qualified clear is also exported so that neighbouring register files can clear themselves. The charge pump itself is outside this block and is not stopped by a clear.

Top module: `stepper_supervisor`

## Requirements
- R1: `err_n` is a registered output. It goes low exactly three clocks after any fault input is sampled high. The fault inputs are thermal warning, thermal shutdown, any X or Y overcurrent bit, any open-coil bit and `cp_low`. `err_n` is high whenever all fault inputs sampled three clocks earlier were low.
- R2: `cp_fail` equals `cp_low` delayed by two clocks, through a two-flop synchroniser.
- R3: `hard_clr` rises on the clock edge that samples `clr_in` high for the `TCLR_CYCLES`-th consecutive time. It stays high while `clr_in` stays high and falls on the first edge that samples `clr_in` low. A shorter burst has no effect on any output.
- R4: One clock after `hard_clr` is high, the block holds its reset values: `err_n`=1, `cp_fail`=0, `step_out`=0, `dir_out`=0 and `step_ready`=0. The settle window then restarts.
- R5: `drv_hiz` is high from the clock after `sleep_req` is sampled high until the clock on which `sleep_req` is sampled low. It is also high while `hard_clr` is high.
- R6: While asleep, `step_out` stays 0 and `dir_out` keeps its value whatever `step_in` and `dir_in` do.
- R7: After `sleep_req` is sampled low, or after a reset or clear, `step_ready` stays low for `CP_SETTLE_CYCLES` further clocks. When leaving sleep it rises on the (`CP_SETTLE_CYCLES`+1)-th edge, provided `cp_fail` is 0.
- R8: `step_ready` is never high while `cp_fail` is high. This holds at start-up, when the charge pump is still below threshold.
- R9: `step_out` is `step_in` registered by one clock when `step_ready` was high. A step that arrives while `step_ready` is low is dropped and is never replayed.
- R10: `dir_out` takes `dir_in` one clock later when `step_ready` is high, and holds its value otherwise.
- R11: Synchronous active-low `rst_n` gives `err_n`=1, `hard_clr`=0, `drv_hiz`=0, `step_ready`=0, `step_out`=0 and `dir_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_in | input | 1 | Hard-clear request, active high, qualified by length |
| sleep_req | input | 1 | Sleep bit from the control register, 1 = sleep |
| tw_flag | input | 1 | Thermal warning |
| tsd_flag | input | 1 | Thermal shutdown |
| ovc_x_flag | input | OVC_X_N | Overcurrent flags of the X bridge |
| ovc_y_flag | input | OVC_Y_N | Overcurrent flags of the Y bridge |
| open_flag | input | COIL_N | Open-coil flags |
| cp_low | input | 1 | Charge pump below threshold |
| step_in | input | 1 | Step command input |
| dir_in | input | 1 | Direction input |
| err_n | output | 1 | Registered active-low error line |
| cp_fail | output | 1 | Charge-pump failure status bit |
| drv_hiz | output | 1 | Drivers to high impedance |
| step_ready | output | 1 | Step commands accepted |
| step_out | output | 1 | Gated step to the sequencer |
| dir_out | output | 1 | Gated direction to the sequencer |
| hard_clr | output | 1 | Qualified hard clear, for neighbouring registers |

## Verification
The bench builds the block with `TCLR_CYCLES`=4 and `CP_SETTLE_CYCLES`=6. It uses two flags per bridge and two coils. With these values a full settle window and a clear burst one clock short of qualifying each take only a handful of cycles. Random stimulus therefore often lands in the awkward overlaps: sleep requested during settling, a clear arriving in the middle of a wake, and the charge pump dropping after the window has expired. Directed passes pin down the exact rise edge of `step_ready` after wake and the three-clock error latency for each fault bit on its own.

// File: rtl/stepsup_pkg.sv
// Shared types for the stepper sleep and fault supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package stepsup_pkg;

    // Operating phase of the wake sequencer.
    typedef enum logic [1:0] {
        PH_SETTLE = 2'd0,
        PH_RUN    = 2'd1,
        PH_DOZE   = 2'd2
    } phase_t;

endpackage

// File: rtl/sup_clr_qualifier.sv
// Length qualifier for the hard-clear request.
// Raises hard_clr on the TCLR_CYCLES-th consecutive high sample of clr_in and
// drops it on the first low sample. Assumes clr_in is synchronous to clk.
module sup_clr_qualifier #(
    parameter int TCLR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_in,
    output logic hard_clr
);

    localparam int CW = $clog2(TCLR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TCLR_CYCLES - 1);

    logic [CW-1:0] run_len;

    // Count consecutive high samples; qualify at the programmed length.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_in) begin
            run_len  <= '0;
            hard_clr <= 1'b0;
        end else if (run_len == LAST) begin
            hard_clr <= 1'b1;
        end else begin
            run_len <= run_len + CW'(1);
        end
    end

endmodule

// File: rtl/sup_flag_sync.sv
// Multi-stage synchroniser bank for asynchronous fault flags.
// Every bit passes through STAGES flops; reset clears all stages.
// Assumes: each flag is a level that is stable for longer than STAGES clocks.
module sup_flag_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw flags.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Later stages shift the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sup_fault_merge.sv
// Merges synchronised fault flags into a registered active-low error line.
// Assumes: the flags are already synchronous to clk.
module sup_fault_merge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags,
    output logic         err_n
);

    // Register the NOR of all flags so the pin carries no glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) err_n <= 1'b1;
        else        err_n <= ~(|flags);
    end

endmodule

// File: rtl/sup_wake_seq.sv
// Sleep / settle / run sequencer with step and direction gating.
// After reset or wake it waits CP_SETTLE_CYCLES clocks before step commands
// are taken, and it also needs cp_fail low. Steps seen while blocked are dropped.
// Assumes: sleep_req, step_in and dir_in are synchronous to clk.
module sup_wake_seq
    import stepsup_pkg::*;
#(
    parameter int CP_SETTLE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic cp_fail,
    input  logic step_in,
    input  logic dir_in,
    output logic asleep,
    output logic ready,
    output logic step_out,
    output logic dir_out
);

    localparam int CW = $clog2(CP_SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CP_SETTLE_CYCLES - 1);

    phase_t        phase;
    logic [CW-1:0] settle_cnt;

    assign asleep = (phase == PH_DOZE);
    assign ready  = (phase == PH_RUN) && !cp_fail;

    // Phase transitions and the settle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_SETTLE;
            settle_cnt <= '0;
        end else begin
            case (phase)
                PH_SETTLE: begin
                    if (sleep_req)                phase <= PH_DOZE;
                    else if (settle_cnt == LAST)  phase <= PH_RUN;
                    else                          settle_cnt <= settle_cnt + CW'(1);
                end
                PH_RUN: begin
                    if (sleep_req) phase <= PH_DOZE;
                end
                PH_DOZE: begin
                    if (!sleep_req) begin
                        phase      <= PH_SETTLE;
                        settle_cnt <= '0;
                    end
                end
                default: phase <= PH_SETTLE;
            endcase
        end
    end

    // Pass steps and direction only while ready; drop anything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_out <= 1'b0;
            dir_out  <= 1'b0;
        end else begin
            step_out <= step_in && ready;
            if (ready) dir_out <= dir_in;
        end
    end

endmodule

// File: rtl/stepper_supervisor.sv
// Top of the stepper sleep and fault supervisor.
// Qualifies the hard clear, synchronises the fault flags, drives the error
// line and the charge-pump status, and sequences sleep and wake.
// Assumes: clr_in, sleep_req, step_in and dir_in are synchronous to clk;
// the fault flags may be asynchronous.
module stepper_supervisor #(
    parameter int TCLR_CYCLES      = 16,
    parameter int CP_SETTLE_CYCLES = 2000,
    parameter int OVC_X_N          = 4,
    parameter int OVC_Y_N          = 4,
    parameter int COIL_N           = 2,
    parameter int SYNC_STAGES      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_in,
    input  logic               sleep_req,
    input  logic               tw_flag,
    input  logic               tsd_flag,
    input  logic [OVC_X_N-1:0] ovc_x_flag,
    input  logic [OVC_Y_N-1:0] ovc_y_flag,
    input  logic [COIL_N-1:0]  open_flag,
    input  logic               cp_low,
    input  logic               step_in,
    input  logic               dir_in,
    output logic               err_n,
    output logic               cp_fail,
    output logic               drv_hiz,
    output logic               step_ready,
    output logic               step_out,
    output logic               dir_out,
    output logic               hard_clr
);

    // Flag vector layout: charge-pump indication at bit 0.
    localparam int FW = 2 + OVC_X_N + OVC_Y_N + COIL_N + 1;

    logic          core_rst_n;
    logic [FW-1:0] raw_flags;
    logic [FW-1:0] sync_flags;
    logic          seq_asleep;
    logic          seq_ready;

    assign core_rst_n = rst_n && !hard_clr;
    assign raw_flags  = {tw_flag, tsd_flag, ovc_x_flag, ovc_y_flag, open_flag, cp_low};
    assign cp_fail    = sync_flags[0];
    assign drv_hiz    = seq_asleep || hard_clr;
    assign step_ready = seq_ready && !hard_clr;

    sup_clr_qualifier #(
        .TCLR_CYCLES (TCLR_CYCLES)
    ) u_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_in   (clr_in),
        .hard_clr (hard_clr)
    );

    sup_flag_sync #(
        .W      (FW),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (core_rst_n),
        .d     (raw_flags),
        .q     (sync_flags)
    );

    sup_fault_merge #(
        .W (FW)
    ) u_merge (
        .clk   (clk),
        .rst_n (core_rst_n),
        .flags (sync_flags),
        .err_n (err_n)
    );

    sup_wake_seq #(
        .CP_SETTLE_CYCLES (CP_SETTLE_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .sleep_req (sleep_req),
        .cp_fail   (cp_fail),
        .step_in   (step_in),
        .dir_in    (dir_in),
        .asleep    (seq_asleep),
        .ready     (seq_ready),
        .step_out  (step_out),
        .dir_out   (dir_out)
    );

endmodule

// File: rtl/stepsup_checker.sv
// Property checker for stepper_supervisor, attached through bind.
// Assumes: synchronous active-low reset on rst_n.
module stepsup_checker #(
    parameter int TCLR_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic clr_in,
    input logic sleep_req,
    input logic cp_low,
    input logic err_n,
    input logic cp_fail,
    input logic drv_hiz,
    input logic step_ready,
    input logic step_out,
    input logic dir_out,
    input logic hard_clr
);

    localparam int CW = $clog2(TCLR_CYCLES + 1);

    logic [CW-1:0] hi_cnt;

    // Saturating count of consecutive high clr_in samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_in)                 hi_cnt <= '0;
        else if (hi_cnt != CW'(TCLR_CYCLES))   hi_cnt <= hi_cnt + CW'(1);
    end

    p_err_on_cp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_fail && !hard_clr) |=> !err_n);

    p_cp_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_fail) |-> $past(cp_low, 2));

    p_clr_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_clr) |-> (hi_cnt == CW'(TCLR_CYCLES)));

    p_clr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr |=> (err_n && !cp_fail && !step_out && !step_ready));

    p_hiz_on_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !hard_clr) |=> drv_hiz);

    p_hiz_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drv_hiz |-> !step_ready);

    p_ready_needs_cp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_ready |-> !cp_fail);

    p_no_step_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_ready |=> !step_out);

    p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_ready && !hard_clr) |=> $stable(dir_out));

endmodule

bind stepper_supervisor stepsup_checker #(
    .TCLR_CYCLES (TCLR_CYCLES)
) u_stepsup_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_in     (clr_in),
    .sleep_req  (sleep_req),
    .cp_low     (cp_low),
    .err_n      (err_n),
    .cp_fail    (cp_fail),
    .drv_hiz    (drv_hiz),
    .step_ready (step_ready),
    .step_out   (step_out),
    .dir_out    (dir_out),
    .hard_clr   (hard_clr)
);

// File: tb/stepper_supervisor_tb_top.sv
// Bench for stepper_supervisor: behavioural reference model compared on
// every clock, plus directed checks on the corner cases.
module stepper_supervisor_tb_top;

    localparam int TCLR   = 4;
    localparam int SETTLE = 6;
    localparam int NX     = 2;
    localparam int NY     = 2;
    localparam int NC     = 2;
    localparam int FW     = 2 + NX + NY + NC + 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n     = 1'b0;
    logic          clr_in    = 1'b0;
    logic          sleep_req = 1'b0;
    logic [FW-1:0] flags_drv = '0;
    logic          step_in   = 1'b0;
    logic          dir_in    = 1'b0;
    logic          err_n, cp_fail, drv_hiz, step_ready, step_out, dir_out, hard_clr;

    stepper_supervisor #(
        .TCLR_CYCLES      (TCLR),
        .CP_SETTLE_CYCLES (SETTLE),
        .OVC_X_N          (NX),
        .OVC_Y_N          (NY),
        .COIL_N           (NC),
        .SYNC_STAGES      (2)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_in     (clr_in),
        .sleep_req  (sleep_req),
        .tw_flag    (flags_drv[FW-1]),
        .tsd_flag   (flags_drv[FW-2]),
        .ovc_x_flag (flags_drv[NC+NY+1 +: NX]),
        .ovc_y_flag (flags_drv[NC+1 +: NY]),
        .open_flag  (flags_drv[1 +: NC]),
        .cp_low     (flags_drv[0]),
        .step_in    (step_in),
        .dir_in     (dir_in),
        .err_n      (err_n),
        .cp_fail    (cp_fail),
        .drv_hiz    (drv_hiz),
        .step_ready (step_ready),
        .step_out   (step_out),
        .dir_out    (dir_out),
        .hard_clr   (hard_clr)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit cmp_en  = 1'b0;

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Reference model state.
    int            m_ccnt  = 0;
    bit            m_hclr  = 1'b0;
    bit [FW-1:0]   m_pipe[$];
    bit            m_err_n = 1'b1;
    bit            m_asleep = 1'b0;
    int            m_since = 0;
    bit            m_step  = 1'b0;
    bit            m_dir   = 1'b0;

    initial begin
        m_pipe.push_back('0);
        m_pipe.push_back('0);
    end

    // Model: update on each rising edge from the inputs of that edge.
    always @(posedge clk) begin : model
        bit clr_now;
        bit rdy;
        clr_now = !rst_n || m_hclr;
        rdy     = !m_asleep && (m_since >= SETTLE) && !m_pipe[0][0];
        if (!rst_n || !clr_in) begin
            m_ccnt = 0;
            m_hclr = 1'b0;
        end else if (m_ccnt == TCLR - 1) begin
            m_hclr = 1'b1;
        end else begin
            m_ccnt++;
        end
        if (clr_now) begin
            m_pipe.delete();
            m_pipe.push_back('0);
            m_pipe.push_back('0);
            m_err_n  = 1'b1;
            m_asleep = 1'b0;
            m_since  = 0;
            m_step   = 1'b0;
            m_dir    = 1'b0;
        end else begin
            m_err_n = !(|m_pipe[0]);
            void'(m_pipe.pop_front());
            m_pipe.push_back(flags_drv);
            m_step = step_in && rdy;
            if (rdy) m_dir = dir_in;
            if (sleep_req) m_asleep = 1'b1;
            else if (m_asleep) begin
                m_asleep = 1'b0;
                m_since  = 0;
            end else if (m_since < SETTLE) m_since++;
        end
    end

    // Compare every output against the model between edges.
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R1",  "err_n",      err_n,      m_err_n);
            check("R2",  "cp_fail",    cp_fail,    m_pipe[0][0]);
            check("R3",  "hard_clr",   hard_clr,   m_hclr);
            check("R5",  "drv_hiz",    drv_hiz,    m_asleep || m_hclr);
            check("R7",  "step_ready", step_ready,
                  !m_asleep && (m_since >= SETTLE) && !m_pipe[0][0] && !m_hclr);
            check("R9",  "step_out",   step_out,   m_step);
            check("R10", "dir_out",    dir_out,    m_dir);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all R): actual %0d cycles expected below 100000", cyc);
            finish_run();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int clr_left;
        flags_drv = '0;
        flags_drv[0] = 1'b1;          // pump below threshold at power-up
        tick(3);
        cmp_en = 1'b1;
        // R11 reset state
        check("R11", "err_n reset",      err_n,      1'b1);
        check("R11", "hard_clr reset",   hard_clr,   1'b0);
        check("R11", "drv_hiz reset",    drv_hiz,    1'b0);
        check("R11", "step_ready reset", step_ready, 1'b0);
        check("R11", "step_out reset",   step_out,   1'b0);
        check("R11", "dir_out reset",    dir_out,    1'b0);
        rst_n = 1'b1;

        // R8: pump still low past the settle window, steps blocked.
        for (int i = 0; i < 12; i++) begin
            step_in = i[0];
            tick(1);
        end
        check("R8", "ready while pump low", step_ready, 1'b0);
        check("R8", "cp_fail while pump low", cp_fail, 1'b1);
        flags_drv[0] = 1'b0;
        step_in = 1'b0;
        tick(4);
        check("R8", "ready after pump good", step_ready, 1'b1);

        // R9 / R10: normal stepping.
        for (int i = 0; i < 8; i++) begin
            step_in = ~step_in;
            dir_in  = i[1];
            tick(1);
        end
        step_in = 1'b0;
        tick(2);

        // R1: each non-pump fault alone, one-clock pulse, three-clock latency.
        for (int b = 1; b < FW; b++) begin
            flags_drv = '0;
            flags_drv[b] = 1'b1;
            tick(1);
            flags_drv = '0;
            tick(2);
            check("R1", "err_n low three clocks after fault", err_n, 1'b0);
            tick(4);
            check("R1", "err_n high after fault gone", err_n, 1'b1);
        end

        // R3: clear burst one short of qualifying is ignored.
        clr_in = 1'b1;
        tick(TCLR - 1);
        clr_in = 1'b0;
        tick(2);
        check("R3", "short clear ignored", hard_clr, 1'b0);
        check("R3", "ready kept after short clear", step_ready, 1'b1);

        // R3 / R4: qualified clear.
        dir_in = 1'b1;
        tick(1);
        clr_in = 1'b1;
        tick(TCLR);
        check("R3", "clear qualified", hard_clr, 1'b1);
        tick(1);
        check("R4", "ready dropped in clear", step_ready, 1'b0);
        check("R4", "dir_out cleared", dir_out, 1'b0);
        check("R5", "hiz during clear", drv_hiz, 1'b1);
        clr_in = 1'b0;
        tick(1);
        check("R3", "clear released", hard_clr, 1'b0);
        tick(SETTLE + 3);

        // R5 / R6: sleep with traffic.
        sleep_req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step_in = i[0];
            dir_in  = i[1];
            tick(1);
        end
        check("R5", "hiz asleep", drv_hiz, 1'b1);
        check("R6", "no step asleep", step_out, 1'b0);

        // R7 / R9: wake, exact settle edge, early step dropped.
        sleep_req = 1'b0;
        step_in   = 1'b0;
        for (int k = 1; k <= SETTLE + 3; k++) begin
            step_in = (k == 2);
            tick(1);
            if (k == SETTLE)     check("R7", "not ready before window end", step_ready, 1'b0);
            if (k == SETTLE + 1) check("R7", "ready at window end", step_ready, 1'b1);
            check("R9", "early step never replayed", step_out, 1'b0);
        end

        // Sleep during settling.
        sleep_req = 1'b1;
        tick(1);
        sleep_req = 1'b0;
        tick(3);
        sleep_req = 1'b1;
        tick(2);
        sleep_req = 1'b0;
        tick(SETTLE + 3);

        // Random mix.
        clr_left = 0;
        for (int i = 0; i < 4000; i++) begin
            rst_n = ($urandom_range(0, 999) != 0);
            if (clr_left > 0) begin
                clr_in = 1'b1;
                clr_left--;
            end else begin
                clr_in = 1'b0;
                if ($urandom_range(0, 99) < 2) clr_left = $urandom_range(1, TCLR + 2);
            end
            if ($urandom_range(0, 99) < 4) sleep_req = ~sleep_req;
            for (int b = 1; b < FW; b++) flags_drv[b] = ($urandom_range(0, 99) < 3);
            if ($urandom_range(0, 99) < 3) flags_drv[0] = ~flags_drv[0];
            step_in = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 99) < 20) dir_in = ~dir_in;
            tick(1);
        end
        tick(2);
        finish_run();
    end

endmodule